// File: doc/BRIEF.md
# Bit-Serial Constant-Coefficient Multiplier

This block multiplies a two's complement sample that arrives one bit per clock, least significant bit first, by a signed integer constant fixed when the design is elaborated. It emits the product on a single serial output in the same LSB-first order. A single-cycle pulse on the word-boundary input marks the LSB of every sample word. The product is truncated to the word length, so each word of output carries the low `DATA_W` bits of the full product.

The multiplier is a linear pipeline with one one-bit stage per coefficient bit. The sample is broadcast to all stages, and the partial sum moves from the stage for the coefficient MSB toward the stage for the LSB. Before building the chain, the coefficient is reduced to its shortest form: shortest unsigned binary for a positive value, shortest two's complement for a negative one. The sign is then expressed only by the type of stage chosen for the MSB. A lower coefficient bit of one gets an adder stage with a stored carry. A lower bit of zero gets a register that is cleared at the word boundary.

Words may follow one another directly or with idle cycles between them. The output stream is meaningful for `DATA_W` cycles starting one cycle after each boundary pulse.

Top module: `bsm_const_mult`

## Requirements
- R1: While `rst_ni` is low, `prod_o` is 0. With a zero input stream after reset it stays 0.
- R2: Product bit k is on `prod_o` in the cycle after the clock edge that captured sample bit k. Bit k is counted from the cycle in which `frame_i` is 1, which carries bit 0. Product bit 0 equals sample bit 0 AND coefficient bit 0.
- R3: Over the `DATA_W` output cycles of a word, the collected value equals (x * COEF) mod 2^DATA_W. Here x is the word read as a signed `DATA_W`-bit two's complement number.
- R4: A positive coefficient uses its shortest unsigned binary form, with a plain register as the MSB stage. With `DATA_W` = 12 and COEF = 11, the sample 000001101001 (105) yields 010010000011 (1155).
- R5: A negative coefficient uses its shortest two's complement form, with a negating stage as the MSB stage. COEF = -5 (encoded 1011, the same bits as +11) gives x * -5 truncated.
- R6: Zero coefficient bits below the MSB add nothing to the product and only shift it. COEF = -6 (encoded 1010) gives x * -6 truncated.
- R7: A power-of-two coefficient 2^s yields x shifted left by s, with the low s product bits 0 (COEF = 8).
- R8: COEF = +1 reproduces the sample, COEF = -1 gives its negation mod 2^DATA_W, and COEF = 0 gives an all-zero output.
- R9: The `frame_i` pulse clears all carries and the negation state, so every word is computed on its own. This holds for back-to-back words, for words after idle cycles, and for extreme words (all ones, most negative, most positive). Data driven during idle cycles has no effect on the next word.
- R10: A coefficient whose shortest form is wider than `DATA_W` is reduced mod 2^DATA_W (COEF = 4107 behaves as 11 with `DATA_W` = 12).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Bit clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| data_i | input | 1 | Serial sample, LSB first |
| frame_i | input | 1 | High in the cycle that carries a word's LSB |
| prod_o | output | 1 | Serial truncated product, LSB first, one cycle behind the sample |

## Verification
Eight instances run side by side on the same input streams, with coefficients +11, -5, +8, -1, +1, -6, 0 and 4107. Together they separate the positive and negating MSB stages, the zero-bit and adder stages, the shift-only case and the trimming of coefficients wider than the word. The worked 105 by 11 word pins down the bit order and the one-cycle latency. All-ones, most-negative and most-positive words sent back to back expose any carry or negation state that leaks across the boundary pulse. Words separated by random idle cycles full of noise show that only framed bits count. Long runs of random words then test the truncated arithmetic over the whole sample range.

// File: rtl/bsm_pkg.sv
package bsm_pkg;

  // shortest encoding: unsigned for c >= 0, two's complement for c < 0
  function automatic int coef_len(input int c);
    int n;
    n = 1;
    if (c >= 0) begin
      for (int i = 1; i < 31; i++) if ((c >>> i) != 0) n = i + 1;
    end else begin
      for (int i = 1; i < 32; i++) if (c < -(1 <<< (n - 1))) n = n + 1;
    end
    return n;
  endfunction

  function automatic logic coef_bit(input int c, input int pos);
    return logic'((c >>> pos) & 1);
  endfunction

endpackage

// File: rtl/bsm_msb_stage.sv
module bsm_msb_stage #(
  parameter bit NEG = 1'b0,
  parameter bit BIT = 1'b1
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic frame_i,
  output logic out_o
);
  // seen_q: a one has already passed in this word (serial negation state)
  logic seen_q, seen_eff;

  assign seen_eff = frame_i ? 1'b0 : seen_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      seen_q <= 1'b0;
      out_o  <= 1'b0;
    end else begin
      seen_q <= seen_eff | data_i;
      out_o  <= BIT & (data_i ^ (NEG & seen_eff));
    end
  end
endmodule

// File: rtl/bsm_add_stage.sv
module bsm_add_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic frame_i,
  input  logic in_i,
  output logic out_o
);
  logic       carry_q;
  logic [1:0] sum;

  always_comb begin
    sum = {1'b0, data_i};
    if (!frame_i) sum = sum + {1'b0, in_i} + {1'b0, carry_q};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      carry_q <= 1'b0;
      out_o   <= 1'b0;
    end else begin
      carry_q <= sum[1];
      out_o   <= sum[0];
    end
  end
endmodule

// File: rtl/bsm_zero_stage.sv
module bsm_zero_stage (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic frame_i,
  input  logic in_i,
  output logic out_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) out_o <= 1'b0;
    else         out_o <= frame_i ? 1'b0 : in_i;
  end
endmodule

// File: rtl/bsm_const_mult.sv
module bsm_const_mult #(
  parameter int DATA_W = 12,
  parameter int COEF   = 11
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic data_i,
  input  logic frame_i,
  output logic prod_o
);
  import bsm_pkg::*;

  localparam int FULL_LEN = coef_len(COEF);
  // bits at or above DATA_W only reach product bits beyond the word
  localparam bit TRIM     = FULL_LEN > DATA_W;
  localparam int N_STAGE  = TRIM ? DATA_W : FULL_LEN;
  localparam bit MSB_NEG  = (COEF < 0) && !TRIM;

  logic [N_STAGE-1:0] chain;

  for (genvar j = 0; j < N_STAGE; j++) begin : g_stage
    if (j == N_STAGE - 1) begin : g_msb
      bsm_msb_stage #(
        .NEG (MSB_NEG),
        .BIT (coef_bit(COEF, j))
      ) u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .data_i  (data_i),
        .frame_i (frame_i),
        .out_o   (chain[j])
      );
    end else if (coef_bit(COEF, j)) begin : g_one
      bsm_add_stage u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .data_i  (data_i),
        .frame_i (frame_i),
        .in_i    (chain[j+1]),
        .out_o   (chain[j])
      );
    end else begin : g_zero
      bsm_zero_stage u_stage (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .frame_i (frame_i),
        .in_i    (chain[j+1]),
        .out_o   (chain[j])
      );
    end
  end

  assign prod_o = chain[0];

endmodule

// File: rtl/bsm_const_mult_chk.sv
module bsm_const_mult_chk #(
  parameter int DATA_W = 12,
  parameter int COEF   = 11
) (
  input logic clk_i,
  input logic rst_ni,
  input logic data_i,
  input logic frame_i,
  input logic prod_o
);
  localparam logic C0 = bsm_pkg::coef_bit(COEF, 0);
  localparam logic C1 = bsm_pkg::coef_bit(COEF, 1);

  assert_reset_zero_R1: assert property (@(posedge clk_i)
    !rst_ni |-> prod_o == 1'b0);

  assert_lsb_latency_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_i |=> prod_o == ($past(data_i) & C0));

  // product bit 1 depends only on the two low bits of sample and coefficient
  if (DATA_W >= 2) begin : g_bit1
    assert_bit1_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
      frame_i ##1 !frame_i |=>
        prod_o == (($past(data_i) & C0) ^ ($past(data_i, 2) & C1)));
  end

  if (COEF == 1) begin : g_unit
    assert_unit_copy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> prod_o == $past(data_i));
  end

endmodule

bind bsm_const_mult bsm_const_mult_chk #(
  .DATA_W (DATA_W),
  .COEF   (COEF)
) i_bsm_const_mult_chk (.*);

// File: tb/test_bsm_const_mult.sv
`timescale 1ns/1ps
module test_bsm_const_mult;
  localparam int W  = 12;
  localparam int ND = 8;
  localparam int CS [ND] = '{11, -5, 8, -1, 1, -6, 0, 4107};
  localparam string TAGS [ND] = '{"R4", "R5", "R7", "R8", "R8", "R6", "R8", "R10"};

  typedef logic [ND-1:0][W-1:0] exp_t;

  logic clk = 1'b0, rst_n = 1'b0, data = 1'b0, frame = 1'b0;
  logic [ND-1:0] prod;
  int total = 0, bad = 0;
  exp_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  for (genvar g = 0; g < ND; g++) begin : g_dut
    bsm_const_mult #(.DATA_W(W), .COEF(CS[g])) i_bsm_const_mult (
      .clk_i   (clk),
      .rst_ni  (rst_n),
      .data_i  (data),
      .frame_i (frame),
      .prod_o  (prod[g])
    );
  end

  function automatic logic [W-1:0] ref_mul(input logic [W-1:0] x, input int c);
    longint p;
    p = longint'($signed(x)) * longint'(c);
    return p[W-1:0];
  endfunction

  task automatic check(input bit ok, input string tag, input int c,
                       input logic [W-1:0] act, input logic [W-1:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s coef=%0d actual=%0h expected=%0h", tag, c, act, expv);
    end
  endtask

  task automatic send_word(input logic [W-1:0] x, input int gap, input string tag);
    exp_t e;
    for (int d = 0; d < ND; d++) e[d] = ref_mul(x, CS[d]);
    exp_q.push_back(e);
    tag_q.push_back(tag);
    for (int t = 0; t < W; t++) begin
      @(negedge clk);
      data  = x[t];
      frame = (t == 0);
    end
    for (int k = 0; k < gap; k++) begin
      @(negedge clk);
      data  = 1'($urandom);
      frame = 1'b0;
    end
  endtask

  // monitor: bit k of a word is read one cycle after the edge capturing input bit k
  initial begin
    int   idx;
    bit   busy;
    exp_t got;
    idx = 0; busy = 1'b0; got = '0;
    forever begin
      @(posedge clk);
      #1;
      if (!rst_n) begin
        busy = 1'b0;
      end else begin
        if (frame) begin busy = 1'b1; idx = 0; end
        if (busy) begin
          for (int d = 0; d < ND; d++) got[d][idx] = prod[d];
          idx++;
          if (idx == W) begin
            exp_t  e;
            string tg;
            busy = 1'b0;
            if (exp_q.size() == 0) begin
              check(1'b0, "R2 unexpected word", 0, got[0], '0);
            end else begin
              e  = exp_q.pop_front();
              tg = tag_q.pop_front();
              for (int d = 0; d < ND; d++)
                check(got[d] == e[d], {tg, " ", TAGS[d]}, CS[d], got[d], e[d]);
            end
          end
        end
      end
    end
  end

  initial begin
    #(4 * 200000);
    total++; bad++;
    $display("FAIL watchdog R9 actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    for (int d = 0; d < ND; d++) check(prod[d] == 1'b0, "R1 in reset", CS[d], W'(prod[d]), '0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    for (int d = 0; d < ND; d++) check(prod[d] == 1'b0, "R1 after reset", CS[d], W'(prod[d]), '0);

    // worked example: 105 * 11 = 1155, bit order and latency
    send_word(12'b000001101001, 0, "R2");
    // boundary words back to back, then after noisy idle gaps
    send_word(12'hFFF, 0, "R9");
    send_word(12'h800, 0, "R9");
    send_word(12'h7FF, 0, "R9");
    send_word(12'h800, 0, "R9");
    send_word(12'h000, 0, "R9");
    for (int i = 0; i < 12; i++) send_word(W'($urandom), 1 + ($urandom % 3), "R9");
    // random words for the truncated arithmetic
    for (int i = 0; i < 60; i++) send_word(W'($urandom), 0, "R3");
    @(negedge clk);
    frame = 1'b0;
    data  = 1'b0;
    repeat (W + 4) @(negedge clk);
    check(exp_q.size() == 0, "R2 words outstanding", 0, W'(exp_q.size()), '0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule